// File: doc/BRIEF.md
# Trapdoor Configuration Window for a Legacy ATA Task-File Port

This block hides a small bank of timing and control registers behind the register addresses of a legacy ATA task-file port. Software never sees a separate configuration address space. Instead, it opens a window with a fixed access pattern on the port: two back-to-back 16-bit reads of the error-register offset, then a single byte write of a key value to the sector-count offset. While the window is open, every access is withheld from the task file. Byte writes to chosen offsets land in the bank, and a second key value closes the window again.

The bank holds the following registers:
- a read-cycle timing byte and a write-cycle timing byte for each of two attached devices;
- a control byte, whose override code makes the programmed timings take effect;
- a miscellaneous byte, which picks the target device and carries the shared address-setup field.

In each timing byte the upper nibble is a data-active count and the lower nibble is a recovery count. A strap readback path lets software sense the clock-speed strap pin while the window is open.

The block is used by a host bridge that sends each decoded task-file access to this block and to the task file in parallel. The bridge forwards an access to the drive only when the pass-through enable is high.

Top module: `trapdoor_cfg`

## Requirements
- R1: After reset, and after any later reset, the window is closed. The control and miscellaneous registers read 0x00, every effective timing output reads the default 0x6B, and the effective address setup reads 3.
- R2: The window opens when three accesses occur in order: a 16-bit read of offset 1, another 16-bit read of offset 1, and a byte write of 0x03 to offset 2. `cfg_open` is high from the cycle after the write.
- R3: Any access that departs from the R2 pattern returns the detector to its start state. Examples are a byte read, another offset, a wrong key value, or a third read in place of the key. Cycles with no access (`acc_vld` low) do not break the pattern.
- R4: While the window is closed, `tf_pass` equals `acc_vld`, and this includes the two unlocking reads. The key write that opens the window, and every access while the window is open, drive `tf_pass` low.
- R5: While open, a byte write to offset 0 loads the read-timing byte, and a byte write to offset 1 loads the write-timing byte. Each write goes to the device selected by bit 0 of the miscellaneous register (0 selects device 0, 1 selects device 1).
- R6: While open, a byte write to offset 3 loads the control register and a byte write to offset 6 loads the miscellaneous register. The effective address-setup value is taken from miscellaneous bits 5:4.
- R7: The timing and address-setup outputs show the programmed values only while the control register holds 0x85. At any other control value they show the defaults of R1.
- R8: While open, a byte write of 0x83 to offset 2 closes the window from the next cycle. Programmed register values are kept.
- R9: While open, a byte write of 0xFF to offset 5 arms the strap readback. A later 16-bit read of offset 5 then returns the synchronized strap pin in `cfg_rdata` bit 0, with all other bits zero. When unarmed or closed, `cfg_rdata` is zero.
- R10: While the window is closed, writes to any offset leave every bank register unchanged.
- R11: While open, 16-bit writes change no bank register and do not close the window, whatever their data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_pin | input | 1 | Clock-speed strap, asynchronous |
| acc_vld | input | 1 | One task-file access this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_off | input | 3 | Register offset within the task-file block |
| acc_wdata | input | 8 | Low write-data lane |
| tf_pass | output | 1 | Forward this access to the task file |
| cfg_open | output | 1 | Configuration window open |
| cfg_rdata | output | 16 | Configuration read data (strap readback) |
| ctrl_reg | output | 8 | Control register |
| misc_reg | output | 8 | Miscellaneous register |
| dev0_rd_tim | output | 8 | Effective read timing, device 0 |
| dev0_wr_tim | output | 8 | Effective write timing, device 0 |
| dev1_rd_tim | output | 8 | Effective read timing, device 1 |
| dev1_wr_tim | output | 8 | Effective write timing, device 1 |
| addr_setup | output | 2 | Effective shared address-setup count |

## Verification
Some behaviours are checked on every cycle:
- pass-through gating when closed and when open;
- the window rising only after a key write;
- closing on the lock key;
- the control and miscellaneous registers holding while closed or under 16-bit writes;
- default timing outputs whenever the override code is absent;
- zero read data while closed.

Other behaviours can only be shown by the bench's scenarios:
- which exact access pattern opens or fails to open the window, including a third read, idle gaps and wrong keys;
- that timing writes are routed to the device chosen in the miscellaneous register;
- the armed strap readback value;
- the state after a reset in mid-use.

// File: rtl/trapdoor_pkg.sv
package trapdoor_pkg;
  localparam int OFF_W = 3;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RD1  = 2'd1,
    SQ_RD2  = 2'd2,
    SQ_OPEN = 2'd3
  } sq_state_t;

  localparam logic [OFF_W-1:0] OFF_RDT   = 3'd0;
  localparam logic [OFF_W-1:0] OFF_KEYRD = 3'd1;
  localparam logic [OFF_W-1:0] OFF_WRT   = 3'd1;
  localparam logic [OFF_W-1:0] OFF_KEYWR = 3'd2;
  localparam logic [OFF_W-1:0] OFF_CTL   = 3'd3;
  localparam logic [OFF_W-1:0] OFF_STRAP = 3'd5;
  localparam logic [OFF_W-1:0] OFF_MISC  = 3'd6;

  localparam logic [7:0] KEY_OPEN  = 8'h03;
  localparam logic [7:0] KEY_LOCK  = 8'h83;
  localparam logic [7:0] KEY_STRAP = 8'hFF;
endpackage

// File: rtl/td_sync.sv
module td_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = d;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/td_seq_detect.sv
module td_seq_detect
  import trapdoor_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic             acc_wide,
  input  logic [OFF_W-1:0] acc_off,
  input  logic [7:0]       acc_wdata,
  output logic             cfg_open,
  output logic             unlock_hit
);
  sq_state_t st_q, st_d;
  logic      is_key_rd, is_open_wr, is_lock_wr, byte_wr;

  always_comb begin
    byte_wr    = acc_vld && acc_wr && !acc_wide;
    is_key_rd  = acc_vld && !acc_wr && acc_wide && (acc_off == OFF_KEYRD);
    is_open_wr = byte_wr && (acc_off == OFF_KEYWR) && (acc_wdata == KEY_OPEN);
    is_lock_wr = byte_wr && (acc_off == OFF_KEYWR) && (acc_wdata == KEY_LOCK);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: if (acc_vld) st_d = is_key_rd  ? SQ_RD1  : SQ_IDLE;
      SQ_RD1:  if (acc_vld) st_d = is_key_rd  ? SQ_RD2  : SQ_IDLE;
      SQ_RD2:  if (acc_vld) st_d = is_open_wr ? SQ_OPEN : SQ_IDLE;
      SQ_OPEN: if (is_lock_wr) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign cfg_open   = (st_q == SQ_OPEN);
  assign unlock_hit = (st_q == SQ_RD2) && is_open_wr;
endmodule

// File: rtl/td_reg_bank.sv
module td_reg_bank
  import trapdoor_pkg::*;
#(
  parameter int         NDEV     = 2,
  parameter logic [7:0] DEF_TIM  = 8'h6B,
  parameter logic [7:0] DEF_CTRL = 8'h00,
  parameter logic [7:0] DEF_MISC = 8'h00,
  localparam int        SEL_W    = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_open,
  input  logic                  acc_vld,
  input  logic                  acc_wr,
  input  logic                  acc_wide,
  input  logic [OFF_W-1:0]      acc_off,
  input  logic [7:0]            acc_wdata,
  input  logic                  strap_bit,
  output logic [NDEV-1:0][7:0]  rd_tim,
  output logic [NDEV-1:0][7:0]  wr_tim,
  output logic [7:0]            ctrl_q,
  output logic [7:0]            misc_q,
  output logic [15:0]           cfg_rdata
);
  logic             bwr, wrd;
  logic [SEL_W-1:0] dev_sel;
  logic             ctl_en, misc_en, arm_en;
  logic             arm_q, arm_d;

  always_comb begin
    bwr     = cfg_open && acc_vld && acc_wr && !acc_wide;
    wrd     = cfg_open && acc_vld && !acc_wr && acc_wide;
    dev_sel = misc_q[SEL_W-1:0];
    ctl_en  = bwr && (acc_off == OFF_CTL);
    misc_en = bwr && (acc_off == OFF_MISC);
    arm_en  = !cfg_open || (bwr && (acc_off == OFF_STRAP));
    arm_d   = cfg_open && (acc_wdata == KEY_STRAP);
  end

  generate
    for (genvar d = 0; d < NDEV; d++) begin : g_dev
      logic rd_en, wr_en;
      always_comb begin
        rd_en = bwr && (acc_off == OFF_RDT) && (dev_sel == SEL_W'(d));
        wr_en = bwr && (acc_off == OFF_WRT) && (dev_sel == SEL_W'(d));
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_tim[d] <= DEF_TIM;
          wr_tim[d] <= DEF_TIM;
        end else begin
          if (rd_en) rd_tim[d] <= acc_wdata;
          if (wr_en) wr_tim[d] <= acc_wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= DEF_CTRL;
      misc_q <= DEF_MISC;
      arm_q  <= 1'b0;
    end else begin
      if (ctl_en)  ctrl_q <= acc_wdata;
      if (misc_en) misc_q <= acc_wdata;
      if (arm_en)  arm_q  <= arm_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (wrd && (acc_off == OFF_STRAP) && arm_q) cfg_rdata[0] = strap_bit;
  end
endmodule

// File: rtl/trapdoor_cfg.sv
module trapdoor_cfg
  import trapdoor_pkg::*;
#(
  parameter logic [7:0] DEF_TIM   = 8'h6B,
  parameter logic [1:0] DEF_SETUP = 2'd3,
  parameter logic [7:0] OVR_CODE  = 8'h85,
  parameter int         SYNC_LEN  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_pin,
  input  logic        acc_vld,
  input  logic        acc_wr,
  input  logic        acc_wide,
  input  logic [2:0]  acc_off,
  input  logic [7:0]  acc_wdata,
  output logic        tf_pass,
  output logic        cfg_open,
  output logic [15:0] cfg_rdata,
  output logic [7:0]  ctrl_reg,
  output logic [7:0]  misc_reg,
  output logic [7:0]  dev0_rd_tim,
  output logic [7:0]  dev0_wr_tim,
  output logic [7:0]  dev1_rd_tim,
  output logic [7:0]  dev1_wr_tim,
  output logic [1:0]  addr_setup
);
  localparam int NDEV = 2;

  logic                 rst_int_n;
  logic                 strap_s;
  logic                 unlock_hit;
  logic                 ovr;
  logic [NDEV-1:0][7:0] rd_tim, wr_tim;

  td_sync #(.STAGES(SYNC_LEN)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  td_sync #(.STAGES(SYNC_LEN)) u_strap_sync (
    .clk(clk), .arst_n(rst_int_n), .d(strap_pin), .q(strap_s)
  );

  td_seq_detect u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_wide(acc_wide),
    .acc_off(acc_off), .acc_wdata(acc_wdata),
    .cfg_open(cfg_open), .unlock_hit(unlock_hit)
  );

  td_reg_bank #(.NDEV(NDEV), .DEF_TIM(DEF_TIM)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .cfg_open(cfg_open),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_wide(acc_wide),
    .acc_off(acc_off), .acc_wdata(acc_wdata), .strap_bit(strap_s),
    .rd_tim(rd_tim), .wr_tim(wr_tim),
    .ctrl_q(ctrl_reg), .misc_q(misc_reg), .cfg_rdata(cfg_rdata)
  );

  always_comb begin
    tf_pass     = acc_vld && !(cfg_open || unlock_hit);
    ovr         = (ctrl_reg == OVR_CODE);
    dev0_rd_tim = ovr ? rd_tim[0] : DEF_TIM;
    dev0_wr_tim = ovr ? wr_tim[0] : DEF_TIM;
    dev1_rd_tim = ovr ? rd_tim[1] : DEF_TIM;
    dev1_wr_tim = ovr ? wr_tim[1] : DEF_TIM;
    addr_setup  = ovr ? misc_reg[5:4] : DEF_SETUP;
  end
endmodule

// File: rtl/trapdoor_cfg_chk.sv
module trapdoor_cfg_chk #(
  parameter logic [7:0] DEF_TIM   = 8'h6B,
  parameter logic [1:0] DEF_SETUP = 2'd3,
  parameter logic [7:0] OVR_CODE  = 8'h85
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_vld,
  input logic        acc_wr,
  input logic        acc_wide,
  input logic [2:0]  acc_off,
  input logic [7:0]  acc_wdata,
  input logic        tf_pass,
  input logic        cfg_open,
  input logic [15:0] cfg_rdata,
  input logic [7:0]  ctrl_reg,
  input logic [7:0]  misc_reg,
  input logic [7:0]  dev0_rd_tim,
  input logic [7:0]  dev0_wr_tim,
  input logic [7:0]  dev1_rd_tim,
  input logic [7:0]  dev1_wr_tim,
  input logic [1:0]  addr_setup
);
  logic key_wr, lock_wr;
  assign key_wr  = acc_vld && acc_wr && !acc_wide && (acc_off == 3'd2) && (acc_wdata == 8'h03);
  assign lock_wr = acc_vld && acc_wr && !acc_wide && (acc_off == 3'd2) && (acc_wdata == 8'h83);

  a_r4_open_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_open |-> !tf_pass);

  a_r4_closed_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !cfg_open && !key_wr) |-> tf_pass);

  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(key_wr));

  a_r8_lock_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && lock_wr) |=> !cfg_open);

  a_r10_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(ctrl_reg) && $stable(misc_reg)));

  a_r11_wide_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && acc_vld && acc_wr && acc_wide) |=> ($stable(ctrl_reg) && $stable(misc_reg) && cfg_open));

  a_r7_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_reg != OVR_CODE) |-> (dev0_rd_tim == DEF_TIM && dev0_wr_tim == DEF_TIM &&
                                dev1_rd_tim == DEF_TIM && dev1_wr_tim == DEF_TIM &&
                                addr_setup == DEF_SETUP));

  a_r9_rdata_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> (cfg_rdata == 16'h0000));
endmodule

bind trapdoor_cfg trapdoor_cfg_chk #(
  .DEF_TIM(DEF_TIM), .DEF_SETUP(DEF_SETUP), .OVR_CODE(OVR_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
  .acc_wide(acc_wide), .acc_off(acc_off), .acc_wdata(acc_wdata),
  .tf_pass(tf_pass), .cfg_open(cfg_open), .cfg_rdata(cfg_rdata),
  .ctrl_reg(ctrl_reg), .misc_reg(misc_reg),
  .dev0_rd_tim(dev0_rd_tim), .dev0_wr_tim(dev0_wr_tim),
  .dev1_rd_tim(dev1_rd_tim), .dev1_wr_tim(dev1_wr_tim),
  .addr_setup(addr_setup)
);

// File: tb/trapdoor_cfg_bench.sv
module trapdoor_cfg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  // {wr, wide, off[2:0], data[7:0], exp_pass, exp_open}
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b0, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd2, 8'h03, 1'b0, 1'b1},
    {1'b0, 1'b1, 3'd3, 8'h00, 1'b0, 1'b1},
    {1'b1, 1'b0, 3'd2, 8'h83, 1'b0, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd0, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd2, 8'h03, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd2, 8'h05, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd2, 8'h03, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd2, 8'h03, 1'b0, 1'b1},
    {1'b1, 1'b1, 3'd2, 8'h83, 1'b0, 1'b1},
    {1'b1, 1'b0, 3'd2, 8'h83, 1'b0, 1'b0}
  };

  logic        clk, rst_n, strap_pin;
  logic        acc_vld, acc_wr, acc_wide;
  logic [2:0]  acc_off;
  logic [7:0]  acc_wdata;
  logic        tf_pass, cfg_open;
  logic [15:0] cfg_rdata;
  logic [7:0]  ctrl_reg, misc_reg, dev0_rd_tim, dev0_wr_tim, dev1_rd_tim, dev1_wr_tim;
  logic [1:0]  addr_setup;

  int n_run, n_fail;
  logic        done;
  logic        pass_s;
  logic [15:0] rdata_s;

  trapdoor_cfg u_trapdoor_cfg (
    .clk(clk), .rst_n(rst_n), .strap_pin(strap_pin),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_wide(acc_wide),
    .acc_off(acc_off), .acc_wdata(acc_wdata),
    .tf_pass(tf_pass), .cfg_open(cfg_open), .cfg_rdata(cfg_rdata),
    .ctrl_reg(ctrl_reg), .misc_reg(misc_reg),
    .dev0_rd_tim(dev0_rd_tim), .dev0_wr_tim(dev0_wr_tim),
    .dev1_rd_tim(dev1_rd_tim), .dev1_wr_tim(dev1_wr_tim),
    .addr_setup(addr_setup)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One access: drive after a falling edge, sample combinational outputs,
  // then return after the next falling edge so registered effects are visible.
  task automatic acc(input logic wr, input logic wide, input logic [2:0] off, input logic [7:0] data);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = wr; acc_wide = wide; acc_off = off; acc_wdata = data;
    #2;
    pass_s  = tf_pass;
    rdata_s = cfg_rdata;
    @(negedge clk);
    acc_vld = 1'b0; acc_wr = 1'b0; acc_wide = 1'b0; acc_off = 3'd0; acc_wdata = 8'h00;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_defaults(input string tag);
    check({tag, " open"},  {15'd0, cfg_open}, 16'd0);
    check({tag, " ctrl"},  {8'd0, ctrl_reg}, 16'h0000);
    check({tag, " misc"},  {8'd0, misc_reg}, 16'h0000);
    check({tag, " d0rd"},  {8'd0, dev0_rd_tim}, 16'h006B);
    check({tag, " d1wr"},  {8'd0, dev1_wr_tim}, 16'h006B);
    check({tag, " setup"}, {14'd0, addr_setup}, 16'd3);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; strap_pin = 1'b1;
    acc_vld = 1'b0; acc_wr = 1'b0; acc_wide = 1'b0; acc_off = 3'd0; acc_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check_defaults("R1 reset");

    // Table walk: R2 unlock, R3 breaks, R4 gating, R8 relock, R11 wide lock write
    for (int i = 0; i < NVEC; i++) begin
      acc(VEC[i][14], VEC[i][13], VEC[i][12:10], VEC[i][9:2]);
      check($sformatf("R2 R3 R4 vec%0d pass", i), {15'd0, pass_s}, {15'd0, VEC[i][1]});
      check($sformatf("R2 R8 R11 vec%0d open", i), {15'd0, cfg_open}, {15'd0, VEC[i][0]});
    end

    // R3: idle cycles inside the pattern do not break it
    acc(1'b0, 1'b1, 3'd1, 8'h00);
    idle_cycle();
    acc(1'b0, 1'b1, 3'd1, 8'h00);
    idle_cycle();
    acc(1'b1, 1'b0, 3'd2, 8'h03);
    check("R3 idle gap opens", {15'd0, cfg_open}, 16'd1);

    // R9: strap readback, unarmed then armed
    acc(1'b0, 1'b1, 3'd5, 8'h00);
    check("R9 unarmed read", rdata_s, 16'h0000);
    acc(1'b1, 1'b0, 3'd5, 8'hFF);
    acc(1'b0, 1'b1, 3'd5, 8'h00);
    check("R9 armed strap read", rdata_s, 16'h0001);

    // R5 R6: program both devices
    acc(1'b1, 1'b0, 3'd6, 8'h00);
    acc(1'b1, 1'b0, 3'd0, 8'h42);
    acc(1'b1, 1'b0, 3'd1, 8'h31);
    acc(1'b1, 1'b0, 3'd6, 8'h21);
    acc(1'b1, 1'b0, 3'd0, 8'h58);
    acc(1'b1, 1'b0, 3'd1, 8'h22);
    check("R6 misc load", {8'd0, misc_reg}, 16'h0021);
    check("R7 no override d0rd", {8'd0, dev0_rd_tim}, 16'h006B);
    check("R7 no override setup", {14'd0, addr_setup}, 16'd3);

    // R11: wide write to a timing offset is ignored
    acc(1'b1, 1'b1, 3'd0, 8'h11);
    check("R11 still open", {15'd0, cfg_open}, 16'd1);

    acc(1'b1, 1'b0, 3'd3, 8'h85);
    check("R6 ctrl load", {8'd0, ctrl_reg}, 16'h0085);
    check("R5 d0 read timing", {8'd0, dev0_rd_tim}, 16'h0042);
    check("R5 d0 write timing", {8'd0, dev0_wr_tim}, 16'h0031);
    check("R5 R11 d1 read timing", {8'd0, dev1_rd_tim}, 16'h0058);
    check("R5 d1 write timing", {8'd0, dev1_wr_tim}, 16'h0022);
    check("R6 R7 setup field", {14'd0, addr_setup}, 16'd2);

    // R8: relock keeps values
    acc(1'b1, 1'b0, 3'd2, 8'h83);
    check("R8 closed", {15'd0, cfg_open}, 16'd0);
    check("R8 kept d0rd", {8'd0, dev0_rd_tim}, 16'h0042);

    // R10: writes while closed have no effect on the bank
    acc(1'b1, 1'b0, 3'd0, 8'h99);
    check("R10 pass while closed", {15'd0, pass_s}, 16'd1);
    check("R10 d0rd unchanged", {8'd0, dev0_rd_tim}, 16'h0042);
    acc(1'b1, 1'b0, 3'd3, 8'h00);
    check("R10 ctrl unchanged", {8'd0, ctrl_reg}, 16'h0085);
    acc(1'b1, 1'b0, 3'd6, 8'h10);
    check("R10 misc unchanged", {8'd0, misc_reg}, 16'h0021);
    acc(1'b0, 1'b1, 3'd5, 8'h00);
    check("R9 closed read zero", rdata_s, 16'h0000);

    // R1: reset in mid-use
    acc(1'b0, 1'b1, 3'd1, 8'h00);
    acc(1'b0, 1'b1, 3'd1, 8'h00);
    acc(1'b1, 1'b0, 3'd2, 8'h03);
    do_reset();
    check_defaults("R1 mid-use reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule